// File: doc/BRIEF.md
# Bridge Read Deadlock Resolver

This block sits between the host-side and secondary-side interfaces of a bidirectional bus bridge and decides whether a host-originated read may go on to the secondary bus. Two reads heading in opposite directions can each end up waiting on the other: the host read cannot drive the secondary bus until the device read finishes, and the device read cannot drive the host bus until the host read finishes. When the resolver sees both reads open together with the host read not yet forwarded, it takes the host read back. It answers that read with a split strobe, or with a retry strobe when splitting is turned off. The device read is always forwarded, so the secondary-bus transaction is sure to make progress.

A split host read stays parked until the device read reports its data returned. The resolver then pulses a release strobe and the host side may issue the read again. When there is no conflict, a host read goes straight through in the cycle it is requested. A wrapping count of resolutions is exposed for observation.

Top module: `deadlock_resolver`

## Requirements
- R1: While reset is asserted and in the first cycle after it, splitStrobe, retryStrobe and releaseStrobe are 0 and resolveCount is 0.
- R2: In the idle state, a host read requested while no device read is pending shows on hostFwdReq in the same cycle, combinationally, with no added cycle.
- R3: devFwdReq equals devRdReq in every cycle, in every state.
- R4: In the idle state, hostRdReq and devRdReq both high is a conflict. hostFwdReq stays 0 in that cycle. With splitEn=1, splitStrobe is 1 for the one cycle after the clock edge that sampled the conflict.
- R5: If splitEn=0 when the conflict is sampled, retryStrobe pulses in place of splitStrobe, and splitStrobe stays 0.
- R6: Each resolution produces exactly one single-cycle strobe, and splitStrobe and retryStrobe are never high together.
- R7: From a resolution until the release, hostFwdReq stays 0 even if hostRdReq is high.
- R8: While a host read is parked, devRdDone sampled high ends the hold. releaseStrobe is then 1 for the following cycle. devRdDone has no effect outside the parked state.
- R9: resolveCount rises by one with each resolution, in the same cycle as the strobe, and wraps modulo 2^CNT_W.
- R10: Once a host read has been forwarded, it stays forwarded while hostRdReq is held, even if a device read then arrives. No conflict is raised for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostRdReq | input | 1 | Host-originated read targeting the secondary bus is pending |
| devRdReq | input | 1 | Device-originated read targeting the host bus is pending |
| devRdDone | input | 1 | Device read has returned its data |
| splitEn | input | 1 | 1 selects a split response, 0 selects a retry |
| hostFwdReq | output | 1 | Host read allowed onto the secondary bus |
| devFwdReq | output | 1 | Device read allowed onto the host bus |
| splitStrobe | output | 1 | One-cycle split response for the host read |
| retryStrobe | output | 1 | One-cycle retry response for the host read |
| releaseStrobe | output | 1 | One-cycle signal that the parked host read may be re-issued |
| resolveCount | output | CNT_W | Wrapping count of resolutions |

## Verification
A wrong state in the controller shows at once on hostFwdReq, because that output is decoded combinationally from the state in the same cycle. If the resolver is stuck in the parked state, hostFwdReq is withheld. If it returns to idle too early, a blocked read is forwarded. A missed or doubled resolution shows one cycle later as a missing, doubled or wrong strobe, and also as a resolveCount that differs from the number of conflicts driven. A release that is lost or spurious appears on releaseStrobe in the cycle after devRdDone.

// File: rtl/drr_pkg.sv
package drr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PASS = 2'd1,
    ST_HELD = 2'd2
  } resState_t;

  typedef struct packed {
    logic detect;
    logic done;
  } ctlStrobes_t;
endpackage

// File: rtl/drr_ctrl.sv
module drr_ctrl
  import drr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostRdReq,
  input  logic        devRdReq,
  input  logic        devRdDone,
  output logic        hostFwdReq,
  output ctlStrobes_t ctl
);
  resState_t stateQ, stateD;

  always_comb begin
    stateD     = stateQ;
    ctl        = '0;
    hostFwdReq = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (hostRdReq && devRdReq) begin
          ctl.detect = 1'b1;
          stateD     = ST_HELD;
        end else if (hostRdReq) begin
          hostFwdReq = 1'b1;
          stateD     = ST_PASS;
        end
      end
      ST_PASS: begin
        hostFwdReq = hostRdReq;
        if (!hostRdReq) stateD = ST_IDLE;
      end
      ST_HELD: begin
        if (devRdDone) begin
          ctl.done = 1'b1;
          stateD   = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  // A resolution always parks the host read, so two detects cannot follow back to back.
  assert_detect_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.detect |=> !ctl.detect);

  // Hold ends only on a completion from the device side.
  assert_done_needs_devdone_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.done |-> devRdDone);

  // A forwarded host read is never withdrawn while still requested.
  assert_owned_kept_R10: assert property (@(posedge clk) disable iff (!rstN)
    (hostFwdReq && hostRdReq) |=> (hostFwdReq || !hostRdReq));
endmodule

// File: rtl/drr_dpath.sv
module drr_dpath
  import drr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      ctl,
  input  logic             splitEn,
  output logic             splitStrobe,
  output logic             retryStrobe,
  output logic             releaseStrobe,
  output logic [CNT_W-1:0] resolveCount
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      splitStrobe   <= 1'b0;
      retryStrobe   <= 1'b0;
      releaseStrobe <= 1'b0;
      resolveCount  <= '0;
    end else begin
      splitStrobe   <= ctl.detect && splitEn;
      retryStrobe   <= ctl.detect && !splitEn;
      releaseStrobe <= ctl.done;
      if (ctl.detect) resolveCount <= resolveCount + CNT_ONE;
    end
  end

  assert_no_double_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(splitStrobe && retryStrobe));

  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (splitStrobe || retryStrobe) |-> resolveCount == CNT_W'($past(resolveCount) + CNT_ONE));

  assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(splitStrobe || retryStrobe) |-> $stable(resolveCount));

  assert_split_follows_en_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.detect) |-> (splitStrobe == $past(splitEn)));
endmodule

// File: rtl/deadlock_resolver.sv
module deadlock_resolver
  import drr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostRdReq,
  input  logic             devRdReq,
  input  logic             devRdDone,
  input  logic             splitEn,
  output logic             hostFwdReq,
  output logic             devFwdReq,
  output logic             splitStrobe,
  output logic             retryStrobe,
  output logic             releaseStrobe,
  output logic [CNT_W-1:0] resolveCount
);
  ctlStrobes_t ctl;

  // The device-side read is never blocked: forward progress on the secondary bus.
  assign devFwdReq = devRdReq;

  drr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostRdReq  (hostRdReq),
    .devRdReq   (devRdReq),
    .devRdDone  (devRdDone),
    .hostFwdReq (hostFwdReq),
    .ctl        (ctl)
  );

  drr_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .splitEn       (splitEn),
    .splitStrobe   (splitStrobe),
    .retryStrobe   (retryStrobe),
    .releaseStrobe (releaseStrobe),
    .resolveCount  (resolveCount)
  );

  // In the cycle a response is sent back, the host read is not on the secondary bus.
  assert_blocked_on_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    (splitStrobe || retryStrobe) |-> !hostFwdReq);

  assert_release_after_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    releaseStrobe |-> $past(devRdDone));

  assert_strobe_one_cycle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (splitStrobe || retryStrobe) |=> !(splitStrobe || retryStrobe));
endmodule

// File: tb/deadlock_resolver_test.sv
module deadlock_resolver_test;
  localparam int CNT_W = 8;
  localparam int NVEC  = 14;

  logic clk = 1'b0;
  logic rstN, hostRdReq, devRdReq, devRdDone, splitEn;
  logic hostFwdReq, devFwdReq, splitStrobe, retryStrobe, releaseStrobe;
  logic [CNT_W-1:0] resolveCount;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  deadlock_resolver #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .hostRdReq(hostRdReq), .devRdReq(devRdReq),
    .devRdDone(devRdDone), .splitEn(splitEn), .hostFwdReq(hostFwdReq),
    .devFwdReq(devFwdReq), .splitStrobe(splitStrobe), .retryStrobe(retryStrobe),
    .releaseStrobe(releaseStrobe), .resolveCount(resolveCount)
  );

  // {expCount[3:0], host, dev, done, en, expFwd, expSplit, expRetry, expRelease}
  localparam logic [11:0] VECS [NVEC] = '{
    {4'd0, 4'b0001, 4'b0000},  // idle
    {4'd0, 4'b1001, 4'b1000},  // R2 pass-through
    {4'd0, 4'b1101, 4'b1000},  // R10 owned read kept
    {4'd0, 4'b0101, 4'b0000},
    {4'd0, 4'b0001, 4'b0000},
    {4'd1, 4'b1101, 4'b0100},  // R4 conflict -> split
    {4'd1, 4'b1101, 4'b0000},  // R7 held, R6 one cycle
    {4'd1, 4'b0111, 4'b0001},  // R8 release
    {4'd1, 4'b0001, 4'b0000},
    {4'd2, 4'b1100, 4'b0010},  // R5 retry
    {4'd2, 4'b0110, 4'b0001},  // R8
    {4'd2, 4'b0011, 4'b0000},  // R8 done ignored in idle
    {4'd2, 4'b1001, 4'b1000},  // R2
    {4'd2, 4'b0001, 4'b0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic h, input logic d, input logic dn, input logic en);
    @(negedge clk);
    hostRdReq = h; devRdReq = d; devRdDone = dn; splitEn = en;
  endtask

  initial begin
    rstN = 1'b0; hostRdReq = 0; devRdReq = 0; devRdDone = 0; splitEn = 1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 split in reset", {31'd0, splitStrobe}, 0);
    check("R1 retry in reset", {31'd0, retryStrobe}, 0);
    check("R1 release in reset", {31'd0, releaseStrobe}, 0);
    check("R1 count in reset", {24'd0, resolveCount}, 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 count after reset", {24'd0, resolveCount}, 0);
    check("R1 strobes after reset", {29'd0, splitStrobe, retryStrobe, releaseStrobe}, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [11:0] v;
      v = VECS[i];
      drive(v[7], v[6], v[5], v[4]);
      #1;
      check($sformatf("R2/R4/R7/R10 hostFwd vec %0d", i), {31'd0, hostFwdReq}, {31'd0, v[3]});
      check($sformatf("R3 devFwd vec %0d", i), {31'd0, devFwdReq}, {31'd0, v[6]});
      @(posedge clk); #1;
      check($sformatf("R4/R5/R6 strobes vec %0d", i), {30'd0, splitStrobe, retryStrobe}, {30'd0, v[2], v[1]});
      check($sformatf("R8 release vec %0d", i), {31'd0, releaseStrobe}, {31'd0, v[0]});
      check($sformatf("R9 count vec %0d", i), {24'd0, resolveCount}, {28'd0, v[11:8]});
    end

    // R9 wrap: 254 more resolutions bring the count from 2 through 255 to 0.
    for (int k = 0; k < 254; k++) begin
      drive(1, 1, 0, k[0]);
      drive(0, 1, 1, 1);
      if (k == 252) begin
        @(posedge clk); #1;
        check("R9 count at 255", {24'd0, resolveCount}, 255);
      end
    end
    drive(0, 0, 0, 1);
    @(posedge clk); #1;
    check("R9 count wrapped", {24'd0, resolveCount}, 0);

    // R7: host held high through the parked period is not forwarded until released.
    drive(1, 1, 0, 1);
    for (int k = 0; k < 3; k++) begin
      drive(1, 1, 0, 1);
      #1;
      check("R7 held host not forwarded", {31'd0, hostFwdReq}, 0);
    end
    drive(1, 0, 1, 1);
    #1;
    check("R7 still held in done cycle", {31'd0, hostFwdReq}, 0);
    drive(1, 0, 0, 1);
    #1;
    check("R2 re-issue forwarded after release", {31'd0, hostFwdReq}, 1);
    check("R8 release seen", {31'd0, releaseStrobe}, 1);
    drive(0, 0, 0, 1);
    @(posedge clk); #1;

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule